// File: doc/BRIEF.md
# Serial-to-CAN Echo-Masking Bridge

This block joins a processor's asynchronous serial port to the logic-level transmit and receive pins of a CAN transceiver. Whatever the processor transmits is driven onto the transceiver transmit pin. Whatever the bus returns on the transceiver receive pin is handed back to the processor's receive line. Start, data and stop bits pass through unchanged. The block does no framing, baud detection, error checking or protocol handling.

The bus reflects every dominant bit the local node drives. That echo would otherwise reach the processor's own receiver and look like the start bit of an incoming frame. To stop this, the receive path is gated by the local transmit line. While the processor drives a 0, its receive line is held at the idle level 1.

Both inputs are synchronized by a two-flop chain. A small classifier state machine then records which side owns the link in each cycle:

- LINK_IDLE: both synchronized lines are 1.
- LINK_HOST_DRIVE: the processor line is 0.
- LINK_BUS_DRIVE: the processor line is 1 and the bus line is 0.

The machine picks its next state directly from the synchronized pair. From any state:

- It takes the to-host transition when the processor line is 0. This has the highest priority.
- Otherwise it takes the to-bus transition when the bus line is 0.
- Otherwise it takes the to-idle transition.

The outputs are decoded from the registered state.

Top module: `can_uart_echo_bridge`

## Requirements
- R1: Inputs held at 1 produce 1 on both outputs, which is the idle level.
- R2: `xcvr_txd_o` equals the value `host_txd_i` had exactly 3 clock cycles earlier.
- R3: Whenever the delayed `host_txd_i` value is 0, `host_rxd_o` is 1, whatever `xcvr_rxd_i` does.
- R4: Whenever the delayed `host_txd_i` value is 1, `host_rxd_o` equals the value `xcvr_rxd_i` had exactly 3 cycles earlier.
- R5: Both paths carry the same latency. An echo that falls and rises in the same cycles as the transmitted 0 never produces a 0 on `host_rxd_o`, including at its edges.
- R6: When both inputs drop to 0 in the same cycle, the transmit direction wins. `xcvr_txd_o` goes to 0 and `host_rxd_o` stays at 1.
- R7: Each input passes two synchronizer flops and one output state register. An input change is visible on the outputs after the third rising edge and not after the second.
- R8: `rst` is synchronous and active high. It drives both outputs and every synchronizer stage to 1, and no 0 appears on either output in the cycles after it is released.
- R9: A 10-bit serial frame at 115200 bps passes in either direction bit for bit. Each frame is a 0 start bit, 8 data bits least significant first, and a 1 stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, far faster than the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| host_txd_i | input | 1 | Processor serial transmit line (asynchronous) |
| xcvr_rxd_i | input | 1 | Transceiver receive pin (asynchronous) |
| xcvr_txd_o | output | 1 | Transceiver transmit pin |
| host_rxd_o | output | 1 | Processor serial receive line |

## Verification
Every result is due exactly three rising edges after the input edge that causes it. The bench drives inputs on falling edges and keeps its own three-deep record of the past inputs. It compares both outputs on every falling edge against the value its model predicts from the input three cycles back. Directed latency checks also look one cycle early, after the second edge, to confirm the output has not yet moved. Frame checks sample mid-bit, where the three-cycle delay is negligible against a 1736-cycle bit.

// File: rtl/can_uart_echo_bridge_pkg.sv
`timescale 1ns/1ps
package can_uart_echo_bridge_pkg;

    // Which side currently owns the link, as seen after synchronization.
    typedef enum logic [1:0] {
        LINK_IDLE       = 2'b00,
        LINK_HOST_DRIVE = 2'b01,
        LINK_BUS_DRIVE  = 2'b10
    } link_state_e;

    // Idle level of a serial line.
    localparam logic LINE_IDLE = 1'b1;

endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
module bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q_o = chain[LAST];

endmodule

// File: rtl/echo_mask_fsm.sv
`timescale 1ns/1ps
module echo_mask_fsm
    import can_uart_echo_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic host_s_i,   // synchronized processor transmit line
    input  logic bus_s_i,    // synchronized transceiver receive line
    output logic xcvr_txd_o,
    output logic host_rxd_o
);
    link_state_e state_q, state_d;

    // Next state: transmit direction has priority.
    always_comb begin
        if (!host_s_i)     state_d = LINK_HOST_DRIVE;
        else if (!bus_s_i) state_d = LINK_BUS_DRIVE;
        else               state_d = LINK_IDLE;
    end

    // State register, also the output register of both paths.
    always_ff @(posedge clk) begin
        if (rst) state_q <= LINK_IDLE;
        else     state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        xcvr_txd_o = LINE_IDLE;
        host_rxd_o = LINE_IDLE;
        unique case (state_q)
            LINK_IDLE: begin
                xcvr_txd_o = LINE_IDLE;
                host_rxd_o = LINE_IDLE;
            end
            LINK_HOST_DRIVE: begin
                xcvr_txd_o = 1'b0;
                host_rxd_o = LINE_IDLE;   // echo hidden
            end
            LINK_BUS_DRIVE: begin
                xcvr_txd_o = LINE_IDLE;
                host_rxd_o = 1'b0;
            end
            default: begin
                xcvr_txd_o = LINE_IDLE;
                host_rxd_o = LINE_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/can_uart_echo_bridge.sv
`timescale 1ns/1ps
module can_uart_echo_bridge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic host_txd_i,
    input  logic xcvr_rxd_i,
    output logic xcvr_txd_o,
    output logic host_rxd_o
);
    import can_uart_echo_bridge_pkg::*;

    logic host_s;
    logic bus_s;

    // Identical chains keep both paths time-aligned for the mask.
    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_IDLE)) u_sync_host (
        .clk (clk),
        .rst (rst),
        .d_i (host_txd_i),
        .q_o (host_s)
    );

    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_IDLE)) u_sync_bus (
        .clk (clk),
        .rst (rst),
        .d_i (xcvr_rxd_i),
        .q_o (bus_s)
    );

    echo_mask_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .host_s_i   (host_s),
        .bus_s_i    (bus_s),
        .xcvr_txd_o (xcvr_txd_o),
        .host_rxd_o (host_rxd_o)
    );

endmodule

// File: rtl/can_uart_echo_bridge_chk.sv
`timescale 1ns/1ps
module can_uart_echo_bridge_chk #(
    parameter int LAT = 3
) (
    input logic clk,
    input logic rst,
    input logic host_txd_i,
    input logic xcvr_rxd_i,
    input logic xcvr_txd_o,
    input logic host_rxd_o
);
    logic [LAT-1:0] h_tx;
    logic [LAT-1:0] h_rx;
    logic           rst_q;

    // Input history of LAT cycles, reset to the idle level.
    always_ff @(posedge clk) begin
        if (rst) begin
            h_tx <= '1;
            h_rx <= '1;
        end else begin
            h_tx <= {h_tx[LAT-2:0], host_txd_i};
            h_rx <= {h_rx[LAT-2:0], xcvr_rxd_i};
        end
    end

    // R8: one edge after a reset cycle, both outputs are at 1.
    always_ff @(posedge clk) begin
        if (rst_q) begin
            a_r8_reset_high: assert (xcvr_txd_o && host_rxd_o)
                else $error("reset did not drive outputs high");
        end
        rst_q <= rst;
    end

    a_r2_tx_follows: assert property (@(posedge clk) disable iff (rst)
        xcvr_txd_o == h_tx[LAT-1]);

    a_r3_echo_masked: assert property (@(posedge clk) disable iff (rst)
        !h_tx[LAT-1] |-> host_rxd_o);

    a_r4_rx_follows: assert property (@(posedge clk) disable iff (rst)
        h_tx[LAT-1] |-> host_rxd_o == h_rx[LAT-1]);

    a_r6_tx_wins: assert property (@(posedge clk) disable iff (rst)
        (!h_tx[LAT-1] && !h_rx[LAT-1]) |-> (!xcvr_txd_o && host_rxd_o));

    a_r5_no_edge_leak: assert property (@(posedge clk) disable iff (rst)
        $fell(xcvr_txd_o) |-> host_rxd_o);

endmodule

bind can_uart_echo_bridge can_uart_echo_bridge_chk #(.LAT(SYNC_STAGES + 1)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_txd_i (host_txd_i),
    .xcvr_rxd_i (xcvr_rxd_i),
    .xcvr_txd_o (xcvr_txd_o),
    .host_rxd_o (host_rxd_o)
);

// File: tb/can_uart_echo_bridge_tb.sv
`timescale 1ns/1ps
module can_uart_echo_bridge_tb;

    localparam int BIT_CYC = 1736;   // 115200 bps at 200 MHz

    logic clk = 1'b0;
    logic rst;
    logic host_txd;
    logic xcvr_rxd;
    logic xcvr_txd;
    logic host_rxd;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  chk_on  = 1'b0;
    bit  done    = 1'b0;

    logic [2:0] rt;
    logic [2:0] rr;

    always #2.5 clk = ~clk;

    can_uart_echo_bridge u_dut (
        .clk        (clk),
        .rst        (rst),
        .host_txd_i (host_txd),
        .xcvr_rxd_i (xcvr_rxd),
        .xcvr_txd_o (xcvr_txd),
        .host_rxd_o (host_rxd)
    );

    // Reference: input history three cycles deep.
    always @(posedge clk) begin
        if (rst) begin
            rt <= 3'b111;
            rr <= 3'b111;
        end else begin
            rt <= {rt[1:0], host_txd};
            rr <= {rr[1:0], xcvr_rxd};
        end
    end

    function automatic logic exp_tx(logic [2:0] t);
        return t[2];
    endfunction

    function automatic logic exp_rx(logic [2:0] t, logic [2:0] r);
        return t[2] ? r[2] : 1'b1;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Continuous model comparison (R2, R3, R4).
    always @(negedge clk) begin
        if (chk_on && !rst) begin
            check("R2 xcvr_txd_o", xcvr_txd, exp_tx(rt));
            if (!rt[2]) check("R3 host_rxd_o masked", host_rxd, exp_rx(rt, rr));
            else        check("R4 host_rxd_o", host_rxd, exp_rx(rt, rr));
        end
    end

    // R9: one frame, start + 8 data LSB first + stop, sampled mid-bit.
    task automatic send_frame(bit from_host, logic [7:0] data);
        logic [9:0] bits;
        logic [9:0] seen;
        bits = {1'b1, data, 1'b0};
        for (int i = 0; i < 10; i++) begin
            if (from_host) host_txd = bits[i];
            else           xcvr_rxd = bits[i];
            tick(BIT_CYC / 2);
            seen[i] = from_host ? xcvr_txd : host_rxd;
            tick(BIT_CYC - BIT_CYC / 2);
        end
        check("R9 start bit", seen[0], 1'b0);
        check("R9 stop bit", seen[9], 1'b1);
        n_tests++;
        if (seen[8:1] !== data) begin
            n_fail++;
            $display("FAIL R9 frame data actual=%02h expected=%02h", seen[8:1], data);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'h1BAD_5EED;
        void'($urandom(seed));
        rst = 1'b1; host_txd = 1'b1; xcvr_rxd = 1'b1;
        tick(4);
        check("R8 xcvr_txd_o in reset", xcvr_txd, 1'b1);
        check("R8 host_rxd_o in reset", host_rxd, 1'b1);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            check("R8 xcvr_txd_o after release", xcvr_txd, 1'b1);
            check("R8 host_rxd_o after release", host_rxd, 1'b1);
        end
        tick(6);
        check("R1 idle xcvr_txd_o", xcvr_txd, 1'b1);
        check("R1 idle host_rxd_o", host_rxd, 1'b1);
        chk_on = 1'b1;

        // R7 latency, transmit path
        host_txd = 1'b0;
        tick(2);
        check("R7 tx not yet after 2 edges", xcvr_txd, 1'b1);
        tick(1);
        check("R7 tx after 3 edges", xcvr_txd, 1'b0);
        check("R3 rx held while sending", host_rxd, 1'b1);
        host_txd = 1'b1;
        tick(6);

        // R7 latency, receive path
        xcvr_rxd = 1'b0;
        tick(2);
        check("R7 rx not yet after 2 edges", host_rxd, 1'b1);
        tick(1);
        check("R7 rx after 3 edges", host_rxd, 1'b0);
        xcvr_rxd = 1'b1;
        tick(6);

        // R6 both inputs drop together
        host_txd = 1'b0; xcvr_rxd = 1'b0;
        tick(3);
        check("R6 xcvr_txd_o low", xcvr_txd, 1'b0);
        check("R6 host_rxd_o high", host_rxd, 1'b1);

        // R5 aligned echo: release together, watch every cycle
        tick(4);
        host_txd = 1'b1; xcvr_rxd = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            check("R5 no echo leak", host_rxd, 1'b1);
        end

        // R3 bus toggling under a long transmitted 0
        host_txd = 1'b0;
        for (int i = 0; i < 24; i++) begin
            xcvr_rxd = 1'($urandom_range(0, 1));
            tick(1);
            if (i >= 3) check("R3 masked during toggling", host_rxd, 1'b1);
        end
        host_txd = 1'b1; xcvr_rxd = 1'b1;
        tick(6);

        // R9 frames both ways
        send_frame(1'b1, 8'hA5);
        send_frame(1'b1, 8'h3C);
        send_frame(1'b0, 8'h5A);
        send_frame(1'b0, 8'hC3);

        // Random segments
        for (int s = 0; s < 2500; s++) begin
            host_txd = 1'($urandom_range(0, 1));
            xcvr_rxd = 1'($urandom_range(0, 1));
            tick(int'($urandom_range(1, 6)));
        end
        host_txd = 1'b1; xcvr_rxd = 1'b1;
        tick(6);
        check("R1 idle at end xcvr_txd_o", xcvr_txd, 1'b1);
        check("R1 idle at end host_rxd_o", host_rxd, 1'b1);
        chk_on = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule